// File: doc/BRIEF.md
# Frequency-Control Register Target on a Two-Wire Serial Bus

This block is the control side of a programmable clock synthesizer. It answers on an I2C-compatible two-wire bus, decodes the device-address, register-pointer and data phases, and accepts bursts of writes and reads. The register pointer steps forward after every data byte. It holds an output-divider setting (a 3-bit high-speed divider code and a 7-bit output divider code) and a 38-bit fractional frequency multiplier. These values are packed across six byte registers. Two control registers hold the freeze, new-frequency and reload bits.

Bus writes land in shadow registers. A separate applied copy drives the synthesizer, and it follows the shadows only when the freeze bits allow. Freezing the multiplier alone stops only the multiplier. Freezing the whole oscillator stops the divider and the multiplier together. When the freeze bit is cleared, the stored values move across in one cycle. A new-frequency request produces a one-cycle strobe for the downstream loop. A reload request restores the factory values, which come from parameters. SCL and SDA are sampled on the system clock through synchronisers. The pad is modelled as a data output that is always low, plus an output-enable.

Top module: `freq_ctrl_regs`

## Requirements
- R1: The target drives an acknowledge only for its own 7-bit device address (parameter `DEV_ADDR`). A transfer to any other address gets no acknowledge and leaves every register unchanged.
- R2: A write transfer is START, address with R/W=0, register pointer, then one or more data bytes, each acknowledged, then STOP. The pointer increments after each data byte, so one transfer can fill consecutive registers.
- R3: A read first sets the pointer with a write phase, then uses a repeated START with R/W=1. The target returns bytes MSB first from consecutive registers until the master answers NACK. After that it releases SDA.
- R4: Register 7 holds the divider code in bits 7:5 and the upper five output-divider bits in 4:0. Register 8 holds the lower two output-divider bits in 7:6 and multiplier bits 37:32 in 5:0. Registers 9 to 12 hold multiplier bits 31:0, most significant byte first. With no freeze set, these values appear on `cfg_hsdiv_o`, `cfg_n1_o` and `cfg_rfreq_o`.
- R5: Writes to addresses other than 7–12, 135 and 137 are ignored. Reads from those addresses return 0x00.
- R6: Register 135 has bit 6 = new-frequency, bit 5 = multiplier freeze, bit 4 = tuning-input freeze and bit 0 = reload. Bits 7 and 3:1 read as zero, and bit 4 reads back as written.
- R7: While the multiplier freeze is set, `cfg_rfreq_o` holds its value and the divider outputs still follow writes. Clearing the freeze applies the accumulated multiplier.
- R8: While register 137 bit 4 (oscillator freeze) is set, the divider and multiplier outputs all hold. Clearing the bit updates them together.
- R9: Writing 1 to the new-frequency bit pulses `cfg_strobe_o` for exactly one clock cycle. The bit then reads back as 0.
- R10: Writing 1 to the reload bit loads the default divider and multiplier into both the shadow and the applied registers on the next cycle. The bit then reads back as 0.
- R11: Register 137 reads bit 7 as the variant flag (parameter `VARIANT_FLAG`), bit 4 as the oscillator freeze, and all other bits as zero.
- R12: After reset the outputs carry the default divider and multiplier, the strobe is low and SDA is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Serial data output value (always 0, open drain) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| cfg_hsdiv_o | output | 3 | Applied high-speed divider code |
| cfg_n1_o | output | 7 | Applied output divider code |
| cfg_rfreq_o | output | 38 | Applied fractional multiplier |
| cfg_strobe_o | output | 1 | One-cycle new-frequency strobe |

## Verification
The assertions check the following on every cycle:
- The applied multiplier stays stable while either freeze is set, and the divider stays stable under the oscillator freeze.
- The strobe never lasts longer than one cycle.
- A reload always lands the defaults on the next cycle.
- An address acknowledge starts only when the received address matches.
- Each transmitted bit follows the MSB of the outgoing byte.

Only the bench's scenarios can show the rest. This covers the byte packing across registers 7–12, pointer auto-increment in both directions, the repeated-START read and the NACK at its end, silence toward a foreign address, ignored undocumented registers, and the values that become visible after a freeze is released.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned HS_W = 3;
  localparam int unsigned N1_W = 7;
  localparam int unsigned RF_W = 38;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] A_DIV = 8'd7;
  localparam logic [7:0] A_MIX = 8'd8;
  localparam logic [7:0] A_RF3 = 8'd9;
  localparam logic [7:0] A_RF2 = 8'd10;
  localparam logic [7:0] A_RF1 = 8'd11;
  localparam logic [7:0] A_RF0 = 8'd12;
  localparam logic [7:0] A_CTL = 8'd135;
  localparam logic [7:0] A_DCO = 8'd137;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_REG, S_RACK, S_WR, S_WACK, S_TX, S_MACK, S_TXLD
  } bus_st_e;
endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q[i] <= 1'b1;
        else if (i == 0) ff_q[i] <= d;
        else ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/fcr_i2c_target.sv
module fcr_i2c_target
  import fcr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl,
  input  logic                sda,
  output logic                sda_drive,
  output logic                wr_en,
  output logic [BYTE_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0]   wr_data,
  output logic [BYTE_W-1:0]   rd_addr,
  input  logic [BYTE_W-1:0]   rd_data
);
  localparam logic [3:0] BITS = 4'(BYTE_W);

  bus_st_e             st_q, st_d;
  logic [3:0]          cnt_q, cnt_d;
  logic [BYTE_W-1:0]   sh_q, sh_d, ptr_q, ptr_d;
  logic                rw_q, rw_d, drv_q, drv_d;
  logic                scl_q, sda_q;
  logic                rise, fall, start, stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign rise  = scl & ~scl_q;
  assign fall  = ~scl & scl_q;
  assign start = scl & scl_q & sda_q & ~sda;
  assign stop  = scl & scl_q & ~sda_q & sda;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    drv_d   = drv_q;
    wr_en   = 1'b0;
    if (start) begin
      st_d  = S_ADDR;
      cnt_d = '0;
      drv_d = 1'b0;
    end else if (stop) begin
      st_d  = S_IDLE;
      drv_d = 1'b0;
    end else begin
      case (st_q)
        S_ADDR, S_REG, S_WR: begin
          if (rise && cnt_q < BITS) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda};
            cnt_d = cnt_q + 4'd1;
          end else if (fall && cnt_q == BITS) begin
            if (st_q == S_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                drv_d = 1'b1;
                rw_d  = sh_q[0];
                st_d  = S_AACK;
              end else begin
                st_d = S_IDLE;
              end
            end else if (st_q == S_REG) begin
              ptr_d = sh_q;
              drv_d = 1'b1;
              st_d  = S_RACK;
            end else begin
              wr_en = 1'b1;
              ptr_d = ptr_q + 8'd1;
              drv_d = 1'b1;
              st_d  = S_WACK;
            end
          end
        end
        S_AACK: begin
          if (fall) begin
            if (rw_q) begin
              sh_d  = rd_data;
              drv_d = ~rd_data[7];
              cnt_d = 4'd1;
              ptr_d = ptr_q + 8'd1;
              st_d  = S_TX;
            end else begin
              drv_d = 1'b0;
              cnt_d = '0;
              st_d  = S_REG;
            end
          end
        end
        S_RACK, S_WACK: begin
          if (fall) begin
            drv_d = 1'b0;
            cnt_d = '0;
            st_d  = S_WR;
          end
        end
        S_TXLD: begin
          if (fall) begin
            sh_d  = rd_data;
            drv_d = ~rd_data[7];
            cnt_d = 4'd1;
            ptr_d = ptr_q + 8'd1;
            st_d  = S_TX;
          end
        end
        S_TX: begin
          if (fall) begin
            if (cnt_q < BITS) begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              drv_d = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 4'd1;
            end else begin
              drv_d = 1'b0;
              st_d  = S_MACK;
            end
          end
        end
        S_MACK: begin
          if (rise) st_d = sda ? S_IDLE : S_TXLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      rw_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ptr_q <= ptr_d;
      rw_q  <= rw_d;
      drv_q <= drv_d;
    end
  end

  assign sda_drive = drv_q;
  assign wr_addr   = ptr_q;
  assign wr_data   = sh_q;
  assign rd_addr   = ptr_q;

  // R1
  ack_own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_q) && st_q == S_AACK) |-> (sh_q[7:1] == DEV_ADDR));

  // R3
  tx_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TX) |-> (drv_q == ~sh_q[BYTE_W-1]));
endmodule

// File: rtl/fcr_regs.sv
module fcr_regs
  import fcr_pkg::*;
#(
  parameter logic [HS_W-1:0] DEF_HSDIV    = 3'd1,
  parameter logic [N1_W-1:0] DEF_N1       = 7'd7,
  parameter logic [RF_W-1:0] DEF_RFREQ    = 38'h21_89AB_CDEF,
  parameter logic            VARIANT_FLAG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [HS_W-1:0]   cfg_hsdiv,
  output logic [N1_W-1:0]   cfg_n1,
  output logic [RF_W-1:0]   cfg_rfreq,
  output logic              cfg_strobe
);
  logic [HS_W-1:0] sh_hs_q, sh_hs_d, app_hs_q, app_hs_d;
  logic [N1_W-1:0] sh_n1_q, sh_n1_d, app_n1_q, app_n1_d;
  logic [RF_W-1:0] sh_rf_q, sh_rf_d, app_rf_q, app_rf_d;
  logic nf_q, nf_d, fm_q, fm_d, fv_q, fv_d, rc_q, rc_d, fd_q, fd_d;

  always_comb begin
    sh_hs_d = sh_hs_q;
    sh_n1_d = sh_n1_q;
    sh_rf_d = sh_rf_q;
    nf_d    = 1'b0;
    rc_d    = 1'b0;
    fm_d    = fm_q;
    fv_d    = fv_q;
    fd_d    = fd_q;
    if (rc_q) begin
      sh_hs_d = DEF_HSDIV;
      sh_n1_d = DEF_N1;
      sh_rf_d = DEF_RFREQ;
    end else if (wr_en) begin
      case (wr_addr)
        A_DIV: begin
          sh_hs_d      = wr_data[7:5];
          sh_n1_d[6:2] = wr_data[4:0];
        end
        A_MIX: begin
          sh_n1_d[1:0]   = wr_data[7:6];
          sh_rf_d[37:32] = wr_data[5:0];
        end
        A_RF3: sh_rf_d[31:24] = wr_data;
        A_RF2: sh_rf_d[23:16] = wr_data;
        A_RF1: sh_rf_d[15:8]  = wr_data;
        A_RF0: sh_rf_d[7:0]   = wr_data;
        A_CTL: begin
          nf_d = wr_data[6];
          fm_d = wr_data[5];
          fv_d = wr_data[4];
          rc_d = wr_data[0];
        end
        A_DCO: fd_d = wr_data[4];
        default: ;
      endcase
    end
  end

  always_comb begin
    app_hs_d = app_hs_q;
    app_n1_d = app_n1_q;
    app_rf_d = app_rf_q;
    if (rc_q) begin
      app_hs_d = DEF_HSDIV;
      app_n1_d = DEF_N1;
      app_rf_d = DEF_RFREQ;
    end else if (!fd_q) begin
      app_hs_d = sh_hs_q;
      app_n1_d = sh_n1_q;
      if (!fm_q) app_rf_d = sh_rf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hs_q  <= DEF_HSDIV;
      sh_n1_q  <= DEF_N1;
      sh_rf_q  <= DEF_RFREQ;
      app_hs_q <= DEF_HSDIV;
      app_n1_q <= DEF_N1;
      app_rf_q <= DEF_RFREQ;
      nf_q <= 1'b0;
      fm_q <= 1'b0;
      fv_q <= 1'b0;
      rc_q <= 1'b0;
      fd_q <= 1'b0;
    end else begin
      sh_hs_q  <= sh_hs_d;
      sh_n1_q  <= sh_n1_d;
      sh_rf_q  <= sh_rf_d;
      app_hs_q <= app_hs_d;
      app_n1_q <= app_n1_d;
      app_rf_q <= app_rf_d;
      nf_q <= nf_d;
      fm_q <= fm_d;
      fv_q <= fv_d;
      rc_q <= rc_d;
      fd_q <= fd_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DIV:   rd_data = {sh_hs_q, sh_n1_q[6:2]};
      A_MIX:   rd_data = {sh_n1_q[1:0], sh_rf_q[37:32]};
      A_RF3:   rd_data = sh_rf_q[31:24];
      A_RF2:   rd_data = sh_rf_q[23:16];
      A_RF1:   rd_data = sh_rf_q[15:8];
      A_RF0:   rd_data = sh_rf_q[7:0];
      A_CTL:   rd_data = {1'b0, nf_q, fm_q, fv_q, 3'b000, rc_q};
      A_DCO:   rd_data = {VARIANT_FLAG, 2'b00, fd_q, 4'b0000};
      default: rd_data = '0;
    endcase
  end

  assign cfg_hsdiv  = app_hs_q;
  assign cfg_n1     = app_n1_q;
  assign cfg_rfreq  = app_rf_q;
  assign cfg_strobe = nf_q;

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_q |=> !nf_q);

  // R10
  recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_q |=> (app_rf_q == DEF_RFREQ && sh_rf_q == DEF_RFREQ &&
              app_hs_q == DEF_HSDIV && app_n1_q == DEF_N1 && !rc_q));

  // R8
  dco_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_q && !rc_q) |=> ($stable(app_hs_q) && $stable(app_n1_q) && $stable(app_rf_q)));

  // R7
  m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_q && !rc_q) |=> $stable(app_rf_q));
endmodule

// File: rtl/freq_ctrl_regs.sv
module freq_ctrl_regs
  import fcr_pkg::*;
#(
  parameter logic [6:0]      DEV_ADDR     = 7'h55,
  parameter int unsigned     SYNC_STAGES  = 2,
  parameter logic [HS_W-1:0] DEF_HSDIV    = 3'd1,
  parameter logic [N1_W-1:0] DEF_N1       = 7'd7,
  parameter logic [RF_W-1:0] DEF_RFREQ    = 38'h21_89AB_CDEF,
  parameter logic            VARIANT_FLAG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_o,
  output logic            sda_oe,
  output logic [HS_W-1:0] cfg_hsdiv_o,
  output logic [N1_W-1:0] cfg_n1_o,
  output logic [RF_W-1:0] cfg_rfreq_o,
  output logic            cfg_strobe_o
);
  logic scl_s, sda_s;
  logic wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  fcr_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  fcr_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  fcr_i2c_target #(.DEV_ADDR(DEV_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .sda_drive(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  fcr_regs #(
    .DEF_HSDIV(DEF_HSDIV), .DEF_N1(DEF_N1),
    .DEF_RFREQ(DEF_RFREQ), .VARIANT_FLAG(VARIANT_FLAG)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_hsdiv(cfg_hsdiv_o), .cfg_n1(cfg_n1_o),
    .cfg_rfreq(cfg_rfreq_o), .cfg_strobe(cfg_strobe_o));

  assign sda_o = 1'b0;
endmodule

// File: tb/tb_freq_ctrl_regs.sv
`timescale 1ns/1ps
module tb_freq_ctrl_regs;
  localparam logic [6:0]  DEV   = 7'h55;
  localparam logic [2:0]  D_HS  = 3'd1;
  localparam logic [6:0]  D_N1  = 7'd7;
  localparam logic [37:0] D_RF  = 38'h21_89AB_CDEF;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_o, sda_oe, cfg_strobe;
  logic [2:0] cfg_hs;
  logic [6:0] cfg_n1;
  logic [37:0] cfg_rf;
  logic sda_line;

  int n_tests = 0;
  int n_fail = 0;
  int strobe_cnt = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~(sda_oe & ~sda_o);

  freq_ctrl_regs #(.DEV_ADDR(DEV), .SYNC_STAGES(2), .DEF_HSDIV(D_HS),
    .DEF_N1(D_N1), .DEF_RFREQ(D_RF), .VARIANT_FLAG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .cfg_hsdiv_o(cfg_hs),
    .cfg_n1_o(cfg_n1), .cfg_rfreq_o(cfg_rf), .cfg_strobe_o(cfg_strobe));

  always @(posedge clk) if (cfg_strobe) strobe_cnt <= strobe_cnt + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n*Q) @(negedge clk);
  endtask

  task automatic b_start;
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic b_stop;
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(2);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(nack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic last);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(last);
  endtask

  task automatic wr_seq(input logic [6:0] dev, input logic [7:0] ra, input int n, output logic nack0);
    logic nk;
    b_start();
    send_byte({dev, 1'b0}, nack0);
    if (!nack0) begin
      send_byte(ra, nk);
      for (int i = 0; i < n; i++) send_byte(wbuf[i], nk);
    end
    b_stop();
  endtask

  task automatic wr1(input logic [7:0] ra, input logic [7:0] v);
    logic nk;
    wbuf[0] = v;
    wr_seq(DEV, ra, 1, nk);
  endtask

  task automatic rd_seq(input logic [7:0] ra, input int n);
    logic nk;
    b_start();
    send_byte({DEV, 1'b0}, nk);
    send_byte(ra, nk);
    b_start();
    send_byte({DEV, 1'b1}, nk);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i == n-1);
    b_stop();
  endtask

  task automatic t_reset;
    chk("R12 hsdiv", 64'(cfg_hs), 64'(D_HS));
    chk("R12 n1", 64'(cfg_n1), 64'(D_N1));
    chk("R12 rfreq", 64'(cfg_rf), 64'(D_RF));
    chk("R12 strobe/oe", {62'd0, cfg_strobe, sda_oe}, 64'd0);
  endtask

  task automatic t_write;
    logic nk;
    wbuf[0] = 8'hB5; wbuf[1] = 8'h6A; wbuf[2] = 8'h12;
    wbuf[3] = 8'h34; wbuf[4] = 8'h56; wbuf[5] = 8'h78;
    wr_seq(DEV, 8'd7, 6, nk);
    chk("R2 address ack", 64'(nk), 64'd0);
    chk("R4 hsdiv", 64'(cfg_hs), 64'd5);
    chk("R4 n1", 64'(cfg_n1), 64'b1010101);
    chk("R4 rfreq", 64'(cfg_rf), 64'(38'h2A_1234_5678));
  endtask

  task automatic t_read;
    rd_seq(8'd7, 6);
    for (int i = 0; i < 6; i++) chk("R3 read byte", 64'(rbuf[i]), 64'(wbuf[i]));
    chk("R3 bus released", 64'(sda_oe), 64'd0);
  endtask

  task automatic t_bad_dev;
    logic nk;
    wbuf[0] = 8'h00;
    wr_seq(7'h2A, 8'd7, 1, nk);
    chk("R1 no ack for foreign address", 64'(nk), 64'd1);
    chk("R1 register untouched", 64'(cfg_hs), 64'd5);
  endtask

  task automatic t_undoc;
    logic nk;
    wbuf[0] = 8'hAA; wbuf[1] = 8'hCC;
    wr_seq(DEV, 8'd13, 2, nk);
    rd_seq(8'd13, 1);
    chk("R5 undocumented reads zero", 64'(rbuf[0]), 64'd0);
    rd_seq(8'd12, 1);
    chk("R5 neighbour unchanged", 64'(rbuf[0]), 64'h78);
    chk("R5 rfreq unchanged", 64'(cfg_rf), 64'(38'h2A_1234_5678));
  endtask

  task automatic t_ctl;
    int s0;
    s0 = strobe_cnt;
    wr1(8'd135, 8'h9E);
    rd_seq(8'd135, 1);
    chk("R6 control readback", 64'(rbuf[0]), 64'h10);
    chk("R6 no strobe", 64'(strobe_cnt - s0), 64'd0);
    wr1(8'd135, 8'h00);
  endtask

  task automatic t_freeze_m;
    logic nk;
    wr1(8'd135, 8'h20);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_seq(DEV, 8'd9, 4, nk);
    chk("R7 rfreq held", 64'(cfg_rf), 64'(38'h2A_1234_5678));
    wr1(8'd7, 8'h40);
    chk("R7 divider follows", 64'(cfg_hs), 64'd2);
    chk("R7 n1 follows", 64'(cfg_n1), 64'd1);
    wr1(8'd135, 8'h00);
    chk("R7 rfreq applied", 64'(cfg_rf), 64'(38'h2A_1122_3344));
  endtask

  task automatic t_freeze_dco;
    logic nk;
    wr1(8'd137, 8'h10);
    rd_seq(8'd137, 1);
    chk("R11 frozen readback", 64'(rbuf[0]), 64'h90);
    wbuf[0] = 8'hE0; wbuf[1] = 8'hC5;
    wr_seq(DEV, 8'd7, 2, nk);
    chk("R8 hsdiv held", 64'(cfg_hs), 64'd2);
    chk("R8 n1 held", 64'(cfg_n1), 64'd1);
    chk("R8 rfreq held", 64'(cfg_rf), 64'(38'h2A_1122_3344));
    wr1(8'd137, 8'h00);
    chk("R8 hsdiv applied", 64'(cfg_hs), 64'd7);
    chk("R8 n1 applied", 64'(cfg_n1), 64'd3);
    chk("R8 rfreq applied", 64'(cfg_rf), 64'(38'h05_1122_3344));
    rd_seq(8'd137, 1);
    chk("R11 unfrozen readback", 64'(rbuf[0]), 64'h80);
  endtask

  task automatic t_newfreq;
    int s0;
    s0 = strobe_cnt;
    wr1(8'd135, 8'h40);
    chk("R9 one strobe cycle", 64'(strobe_cnt - s0), 64'd1);
    rd_seq(8'd135, 1);
    chk("R9 bit self-clears", 64'(rbuf[0]), 64'h00);
  endtask

  task automatic t_recall;
    wr1(8'd135, 8'h01);
    chk("R10 hsdiv default", 64'(cfg_hs), 64'(D_HS));
    chk("R10 n1 default", 64'(cfg_n1), 64'(D_N1));
    chk("R10 rfreq default", 64'(cfg_rf), 64'(D_RF));
    rd_seq(8'd9, 1);
    chk("R10 shadow default", 64'(rbuf[0]), 64'(D_RF[31:24]));
    rd_seq(8'd135, 1);
    chk("R10 bit self-clears", 64'(rbuf[0]), 64'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    qw(2);
    t_reset();
    t_write();
    t_read();
    t_bad_dev();
    t_undoc();
    t_ctl();
    t_freeze_m();
    t_freeze_dco();
    t_newfreq();
    t_recall();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule